// File: doc/BRIEF.md
# Character Display Host Bus Port

This block sits between a slow, asynchronous host bus and the command executor of a character display controller. The host drives a strobe, a register-select line, a read/not-write line and eight data lines. The block synchronises these into the controller clock. It takes each transfer on the falling edge of the strobe and sends completed bytes to either the command path or the data path. On reads it drives back either a status byte or the data byte that the executor supplies.

The port has two bus widths. In the wide width, one strobe carries a whole byte. In the narrow width, one byte takes two strobes on the upper four lines. The high half goes first and the low half second. A phase bit tracks which half comes next. The width changes only when a mode-setting command (upper three bits `001`) is accepted. Because of this, a host that sends that command three times with the width bit set always ends up in the wide width, whatever state the port was in.

The executor side uses single-cycle strobes, a byte, and a busy input. While busy is high, completed writes and data reads are dropped. Status reads are always answered.

Top module: `lcd_host_port`

## Requirements
- R1: After synchronous reset the port is in the wide (8-bit) width, with nibble phase 0, no executor strobe and the read drive enable low.
- R2: In the wide width, a strobe with select=0 and read/not-write=0 produces exactly one `cmd_stb` pulse, with `out_byte` equal to the eight data lines.
- R3: A completed write with select=1 produces exactly one `dat_stb` pulse, with `out_byte` equal to the written byte.
- R4: A read with select=0 drives the status byte while the strobe is high: bit 7 is `exec_busy` and bits 6:0 are `exec_addr`.
- R5: A read with select=1 drives `exec_rd_byte`. When the read completes, one `rd_stb` pulse is issued.
- R6: In the narrow width, a byte takes two strobes on data lines 7:4, high half first. The executor strobe comes only after the second strobe, and the byte is {first half, second half}. Reads return the high half on the first strobe and the low half on the second.
- R7: In the narrow width, data lines 3:0 have no effect on written bytes, and they are driven to 0 on reads.
- R8: An accepted command with bits 7:5 = `001` sets the width from bit 4 (1 = wide, 0 = narrow). A change to the wide width clears the nibble phase.
- R9: A write or data read that completes while `exec_busy` is high produces no executor strobe and changes no width. The nibble phase still advances.
- R10: Status reads are answered while `exec_busy` is high, with bit 7 read as 1.
- R11: Three single strobes of 0x30 with select=0, starting from the narrow width at either phase or from the wide width, leave the port in the wide width at phase 0.
- R12: At most one of `cmd_stb`, `dat_stb`, `rd_stb` is high in any cycle.
- R13: `bus_d_oe` is high only while the synchronised strobe is high with read/not-write=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_e | input | 1 | Asynchronous transfer strobe from the host |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_d_in | input | 8 | Data lines as driven by the host |
| bus_d_out | output | 8 | Data lines as driven by the port on reads |
| bus_d_oe | output | 1 | Drive enable for `bus_d_out` |
| exec_busy | input | 1 | Executor busy flag |
| exec_addr | input | 7 | Executor address counter for the status byte |
| exec_rd_byte | input | 8 | Data byte that the executor offers for reads |
| cmd_stb | output | 1 | One-cycle pulse: command byte accepted |
| dat_stb | output | 1 | One-cycle pulse: data byte accepted |
| rd_stb | output | 1 | One-cycle pulse: data read completed |
| out_byte | output | 8 | Byte that goes with `cmd_stb`/`dat_stb` |

## Verification
Some rules are checked by assertions on every cycle: the executor strobes are mutually exclusive, no strobe follows a busy completion, a strobe matches the direction of the transfer that caused it, the phase advances after a first half, and phase 0 with the wide width follows a switch to the wide width. Other behaviour can only be shown by the bench's scenarios, because it depends on the order of whole transfers. This covers the pairing of halves into bytes, low lines having no effect, the status and data read-back values, and the three-strobe recovery from every starting phase. The random mix of commands, data, reads and busy periods also changes the width in the middle of a run, and checks that the bench's own model of the width stays in step with the port.

// File: rtl/lcd_port_pkg.sv
// Shared constants and helpers for the display host bus port.
// Assumes an 8-bit host byte whose top three bits identify the mode command.
package lcd_port_pkg;
    localparam int unsigned FS_TAG_W   = 3;
    localparam logic [2:0]  FS_TAG     = 3'b001;
    localparam int unsigned FS_WIDE_IX = 4;

    // True when a command byte is the mode-setting command.
    function automatic logic is_mode_cmd(input logic [7:0] b);
        return b[7 -: FS_TAG_W] == FS_TAG;
    endfunction
endpackage

// File: rtl/lcd_sync_edge.sv
// Synchronises the host bus bundle {strobe, select, rnw, data} through STAGES
// flops and flags the falling edge of the strobe (the MSB of the bundle).
// Assumes the host holds select, rnw and data steady around the strobe edges,
// so every field of the bundle crosses with the same delay.
module lcd_sync_edge #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced,
    output logic         strobe_fall
);
    logic [STAGES-1:0][W-1:0] stg;
    logic                     lvl_q;

    // Shift the raw bundle through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign synced = stg[STAGES-1];

    // Remember the previous synchronised strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= synced[W-1];
    end

    assign strobe_fall = lvl_q & ~synced[W-1];
endmodule

// File: rtl/lcd_nibble_asm.sv
// Keeps the bus width and the nibble phase, and builds whole bytes from the
// bus. Wide width: every transfer is a byte. Narrow width: the first transfer
// stores the high half and the second completes the byte.
// Assumes width_load is only raised together with a completing transfer.
module lcd_nibble_asm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [DATA_W-1:0] bus_byte,
    input  logic              width_load,
    input  logic              width_val,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val,
    output logic              wide,
    output logic              phase
);
    localparam int unsigned NIB_W = DATA_W / 2;

    logic [NIB_W-1:0] hi_q;

    assign byte_done = xfer & (wide | phase);
    assign byte_val  = wide ? bus_byte : {hi_q, bus_byte[DATA_W-1 -: NIB_W]};

    // Store the high half on the first transfer of a narrow byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hi_q <= '0;
        else if (xfer && !wide && !phase) hi_q <= bus_byte[DATA_W-1 -: NIB_W];
    end

    // Advance the nibble phase per narrow transfer; a switch to wide clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                      phase <= 1'b0;
        else if (width_load && width_val) phase <= 1'b0;
        else if (xfer && !wide)           phase <= ~phase;
    end

    // Hold the bus width; it changes only on an accepted mode command.
    always_ff @(posedge clk) begin
        if (!rst_n)          wide <= 1'b1;
        else if (width_load) wide <= width_val;
    end

    // R8
    wide_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_load && width_val) |=> (wide && !phase));

    // R6
    half_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wide && !phase && !width_load) |=> phase);
endmodule

// File: rtl/lcd_readback.sv
// Chooses the read-back byte (status or data) and fits it to the bus width.
// In the narrow width the selected half goes out on the upper lines and the
// lower lines are driven low. Purely combinational.
module lcd_readback #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic            sel_data,
    input  logic [ADDR_W:0] rd_byte,
    input  logic            busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic            wide,
    input  logic            phase,
    output logic [ADDR_W:0] bus_out
);
    localparam int unsigned DATA_W = ADDR_W + 1;
    localparam int unsigned NIB_W  = DATA_W / 2;

    logic [DATA_W-1:0] sel;

    assign sel = sel_data ? rd_byte : {busy, addr};

    // Place the whole byte or the current half on the bus.
    always_comb begin
        if (wide)        bus_out = sel;
        else if (!phase) bus_out = {sel[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
        else             bus_out = {sel[NIB_W-1:0], {NIB_W{1'b0}}};
    end
endmodule

// File: rtl/lcd_host_port.sv
// Host-side register port of a character display controller. It synchronises
// the asynchronous host bus, assembles bytes in the wide or narrow width,
// sends accepted writes to the command or data strobe, and drives status or
// data on reads. Assumes the executor holds exec_busy for as long as it cannot
// take a byte; completions while busy are dropped.
module lcd_host_port #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_e,
    input  logic          bus_rs,
    input  logic          bus_rnw,
    input  logic [ADDR_W:0] bus_d_in,
    output logic [ADDR_W:0] bus_d_out,
    output logic          bus_d_oe,
    input  logic          exec_busy,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [ADDR_W:0] exec_rd_byte,
    output logic          cmd_stb,
    output logic          dat_stb,
    output logic          rd_stb,
    output logic [ADDR_W:0] out_byte
);
    import lcd_port_pkg::*;

    localparam int unsigned DATA_W = ADDR_W + 1;
    localparam int unsigned SW     = DATA_W + 3;

    logic [SW-1:0]     synced;
    logic              fall;
    logic              e_s, rs_s, rnw_s;
    logic [DATA_W-1:0] d_s;
    logic              byte_done, wide, phase;
    logic [DATA_W-1:0] byte_val;
    logic              wr_ok, width_load;

    lcd_sync_edge #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .raw({bus_e, bus_rs, bus_rnw, bus_d_in}),
        .synced(synced), .strobe_fall(fall)
    );

    assign e_s   = synced[SW-1];
    assign rs_s  = synced[SW-2];
    assign rnw_s = synced[SW-3];
    assign d_s   = synced[DATA_W-1:0];

    assign wr_ok      = byte_done & ~rnw_s & ~exec_busy;
    assign width_load = wr_ok & ~rs_s & is_mode_cmd(byte_val);

    lcd_nibble_asm #(.DATA_W(DATA_W)) asm_i (
        .clk(clk), .rst_n(rst_n), .xfer(fall), .bus_byte(d_s),
        .width_load(width_load), .width_val(byte_val[FS_WIDE_IX]),
        .byte_done(byte_done), .byte_val(byte_val),
        .wide(wide), .phase(phase)
    );

    lcd_readback #(.ADDR_W(ADDR_W)) rb_i (
        .sel_data(rs_s), .rd_byte(exec_rd_byte), .busy(exec_busy),
        .addr(exec_addr), .wide(wide), .phase(phase), .bus_out(bus_d_out)
    );

    assign bus_d_oe = e_s & rnw_s;

    // Issue the executor strobes and hold the last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            dat_stb  <= 1'b0;
            rd_stb   <= 1'b0;
            out_byte <= '0;
        end else begin
            cmd_stb <= wr_ok & ~rs_s;
            dat_stb <= wr_ok & rs_s;
            rd_stb  <= byte_done & rnw_s & rs_s & ~exec_busy;
            if (wr_ok) out_byte <= byte_val;
        end
    end

    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, dat_stb, rd_stb}));

    // R9
    no_busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb || dat_stb || rd_stb) |-> $past(!exec_busy));

    // R2
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb || dat_stb) |-> $past(!rnw_s && fall));

    // R5
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(rnw_s && rs_s));

    // R13
    drive_when_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe |-> (rnw_s && !fall));
endmodule

// File: tb/lcd_host_port_tb_top.sv
// Self-checking bench: directed corner cases plus a seeded random mix.
module lcd_host_port_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, bus_e, bus_rs, bus_rnw, bus_d_oe;
    logic [7:0] bus_d_in, bus_d_out, exec_rd_byte, out_byte;
    logic       exec_busy, cmd_stb, dat_stb, rd_stb;
    logic [6:0] exec_addr;

    lcd_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs),
        .bus_rnw(bus_rnw), .bus_d_in(bus_d_in), .bus_d_out(bus_d_out),
        .bus_d_oe(bus_d_oe), .exec_busy(exec_busy), .exec_addr(exec_addr),
        .exec_rd_byte(exec_rd_byte), .cmd_stb(cmd_stb), .dat_stb(dat_stb),
        .rd_stb(rd_stb), .out_byte(out_byte)
    );

    int   n_cmd = 0, n_dat = 0, n_rd = 0, n_any = 0;
    logic [7:0] last_cmd = '0, last_dat = '0;
    int   checks = 0, errors = 0;
    bit   model_wide = 1'b1;

    // Record every executor strobe between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_stb) begin n_cmd++; last_cmd = out_byte; end
            if (dat_stb) begin n_dat++; last_dat = out_byte; end
            if (rd_stb)  n_rd++;
            if (cmd_stb || dat_stb || rd_stb) n_any++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic strobe(input bit rs, input bit rnw, input logic [7:0] d,
                          output logic [7:0] seen, output bit seen_oe);
        @(negedge clk);
        bus_rs = rs; bus_rnw = rnw; bus_d_in = d;
        repeat (4) @(negedge clk);
        bus_e = 1'b1;
        repeat (6) @(negedge clk);
        seen = bus_d_out; seen_oe = bus_d_oe;
        bus_e = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic raw_wr(input bit rs, input logic [7:0] d);
        logic [7:0] s; bit o;
        strobe(rs, 1'b0, d, s, o);
    endtask

    // Whole-byte write in the current width; low lines random when narrow (R7).
    task automatic wr_byte(input bit rs, input logic [7:0] b);
        if (model_wide) raw_wr(rs, b);
        else begin
            raw_wr(rs, {b[7:4], 4'($urandom)});
            raw_wr(rs, {b[3:0], 4'($urandom)});
        end
        if (!exec_busy && !rs && b[7:5] == 3'b001) model_wide = b[4];
    endtask

    task automatic wr_chk(input bit rs, input logic [7:0] b, input string tag);
        int c0, d0;
        c0 = n_cmd; d0 = n_dat;
        wr_byte(rs, b);
        if (exec_busy)
            chk(n_cmd == c0 && n_dat == d0, tag, n_cmd + n_dat, c0 + d0);
        else if (rs)
            chk(n_dat == d0 + 1 && n_cmd == c0 && last_dat == b, tag, last_dat, b);
        else
            chk(n_cmd == c0 + 1 && n_dat == d0 && last_cmd == b, tag, last_cmd, b);
    endtask

    task automatic rd_byte(input bit rs, output logic [7:0] v, output bit lows_zero, output bit oe_ok);
        logic [7:0] s1, s2; bit o1, o2;
        if (model_wide) begin
            strobe(rs, 1'b1, 8'($urandom), s1, o1);
            v = s1; lows_zero = 1'b1; oe_ok = o1;
        end else begin
            strobe(rs, 1'b1, 8'($urandom), s1, o1);
            strobe(rs, 1'b1, 8'($urandom), s2, o2);
            v = {s1[7:4], s2[7:4]};
            lows_zero = (s1[3:0] == 4'h0) && (s2[3:0] == 4'h0);
            oe_ok = o1 && o2;
        end
    endtask

    // Confirms wide width: one data strobe must deliver the full byte.
    task automatic wide_probe(input string tag);
        int d0;
        d0 = n_dat;
        raw_wr(1'b1, 8'hA5);
        chk(n_dat == d0 + 1 && last_dat == 8'hA5, tag, last_dat, 8'hA5);
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v; bit lz, oe; int c0, r0;
        void'($urandom(32'd20101));
        rst_n = 1'b0; bus_e = 1'b0; bus_rs = 1'b0; bus_rnw = 1'b0; bus_d_in = '0;
        exec_busy = 1'b0; exec_addr = '0; exec_rd_byte = '0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(bus_d_oe == 1'b0 && cmd_stb == 0 && dat_stb == 0 && rd_stb == 0,
            "R1 reset outputs", {bus_d_oe, cmd_stb, dat_stb, rd_stb}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2, R1: first command is taken in one strobe (wide after reset)
        wr_chk(1'b0, 8'h0C, "R2 wide command");
        wr_chk(1'b1, 8'h41, "R3 wide data");

        // R4, R13: status read
        exec_addr = 7'h2A;
        rd_byte(1'b0, v, lz, oe);
        chk(v == 8'h2A, "R4 status byte", v, 8'h2A);
        chk(oe, "R13 drive during read", oe, 1);
        // R10: status while busy
        exec_busy = 1'b1;
        rd_byte(1'b0, v, lz, oe);
        chk(v == 8'hAA, "R10 status while busy", v, 8'hAA);

        // R5: data read and its strobe
        exec_busy = 1'b0; exec_rd_byte = 8'h5C; r0 = n_rd;
        rd_byte(1'b1, v, lz, oe);
        chk(v == 8'h5C && n_rd == r0 + 1, "R5 data read", {v, 8'(n_rd - r0)}, {8'h5C, 8'h01});

        // R9: busy drops data reads, writes and mode commands
        exec_busy = 1'b1; r0 = n_rd;
        rd_byte(1'b1, v, lz, oe);
        chk(n_rd == r0, "R9 read while busy", n_rd - r0, 0);
        wr_chk(1'b1, 8'h77, "R9 data write while busy");
        wr_chk(1'b0, 8'h20, "R9 mode command while busy");
        exec_busy = 1'b0;
        wide_probe("R9 width unchanged after busy command");

        // R8: switch to narrow
        wr_chk(1'b0, 8'h28, "R8 narrow mode command");
        // R6: first half alone gives no strobe
        c0 = n_dat;
        raw_wr(1'b1, 8'h90);
        chk(n_dat == c0, "R6 no strobe after first half", n_dat - c0, 0);
        raw_wr(1'b1, 8'hE3);
        chk(n_dat == c0 + 1 && last_dat == 8'h9E, "R6 byte from halves", last_dat, 8'h9E);
        wr_chk(1'b0, 8'h06, "R6 narrow command");
        exec_rd_byte = 8'hC7;
        rd_byte(1'b1, v, lz, oe);
        chk(v == 8'hC7, "R6 narrow read halves", v, 8'hC7);
        chk(lz, "R7 low lines read as zero", lz, 1);

        // Seeded random mix; the model follows width changes.
        for (int k = 0; k < 40; k++) begin
            int sel;
            logic [7:0] b;
            sel = $urandom % 8;
            exec_busy = ($urandom % 4) == 0;
            b = 8'($urandom);
            if (sel == 0) begin
                exec_addr = 7'($urandom);
                rd_byte(1'b0, v, lz, oe);
                chk(v == {exec_busy, exec_addr} && lz, "R4 random status", v, {exec_busy, exec_addr});
            end else if (sel == 1) begin
                exec_rd_byte = b; r0 = n_rd;
                rd_byte(1'b1, v, lz, oe);
                chk(v == b && n_rd == r0 + (exec_busy ? 0 : 1), "R5 random data read", v, b);
            end else if (sel == 2) begin
                wr_chk(1'b0, {3'b001, b[4:0]}, "R8 random mode command");
            end else begin
                wr_chk(sel[0], b, "R3 random write");
            end
        end
        exec_busy = 1'b0;

        // R11: recovery from narrow phase 1
        if (model_wide) wr_byte(1'b0, 8'h28);
        raw_wr(1'b0, 8'h00);
        repeat (3) raw_wr(1'b0, 8'h30);
        model_wide = 1'b1;
        wide_probe("R11 from narrow phase 1");
        // R11: recovery from narrow phase 0
        wr_byte(1'b0, 8'h28);
        repeat (3) raw_wr(1'b0, 8'h30);
        model_wide = 1'b1;
        wide_probe("R11 from narrow phase 0");
        // R11: from wide
        repeat (3) raw_wr(1'b0, 8'h30);
        wide_probe("R11 from wide");

        // R12: strobes never overlapped
        chk(n_any == n_cmd + n_dat + n_rd, "R12 exclusive strobes", n_any, n_cmd + n_dat + n_rd);
        finish_run();
    end
endmodule